// File: doc/BRIEF.md
# Command-Byte Serial Register Interface

This block is the serial slave port of a converter-style register map. A host reaches it over a chip select, a serial clock, a data input and a data output. Each transaction opens with an 8-bit command byte. The byte is gated by a leading zero and names a direction and one of eight register addresses. The addressed register then moves most-significant bit first, with a length that depends on the address. After that the port falls back to waiting for the next command. The conversion result and the conversion-ready strobe come from outside the block, and the writable registers are driven out as plain vectors.

All logic runs on one system clock. Chip select, serial clock and data input pass through synchronizer stages and then through edge detection. The data input is taken on each rising serial-clock edge, and the output bit changes on each falling edge. The serial clock idles high.

A sticky streaming mode puts every new conversion result on the output when the ready strobe falls, and no command is needed between results. A run of ones on the data input returns the whole port, registers included, to its power-on state. This gives the host a way to recover framing at any point.

Top module: `sri_cmd_if`

## Requirements
- R1: After reset, the mode, configuration, offset, full-scale and output-control registers equal their parameter defaults. Streaming is off and the data output is low.
- R2: While the port waits for a command, each 1 taken on the data input leaves it at the gate position. The first 0 starts the command. The next seven bits fill command bits 6..0: bit 6 is read (1) or write (0), bits 5:3 are the address and bit 2 is the streaming flag.
- R3: A write to address 1 (mode), 2 (configuration), 6 (offset) or 7 (full scale) takes 24 bits, MSB first. A write to address 5 (output control) takes 8 bits. The value updates the register, and the port then waits for a new command.
- R4: A read presents the addressed register MSB first. Addresses 0, 4 and 5 are 8 bits long and the other addresses are 24 bits. Address 4 returns the fixed identity parameter.
- R5: A read of address 0 returns the 8-bit status input.
- R6: A read of address 3 returns the 24-bit conversion word. When mode bit 20 is set, it returns 32 bits instead: the conversion word followed by the status byte.
- R7: A write to address 3 or 4 clocks in that address's read length and changes no register. A write to address 0 has no data phase.
- R8: Command 0x5C turns streaming on with no transfer. In streaming mode, each fall of the ready strobe loads the conversion word, and it shifts out on the following falling edges.
- R9: In streaming mode, command 0x58 received while ready is low ends streaming. Any other command, or 0x58 received while ready is high, is ignored.
- R10: When 40 consecutive 1s are taken on the data input, the whole port returns to its reset state, streaming included. A run of 39 changes nothing.
- R11: Raising chip select aborts any partial transfer and returns the port to waiting for a command. Streaming mode is kept.
- R12: The data input is taken on rising serial-clock edges, and the data output changes only on falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| rdy_n | input | 1 | Active-low conversion-ready strobe (system-clock domain) |
| conv_data_i | input | 24 | Latest conversion word |
| status_i | input | 8 | Status byte |
| mode_o | output | 24 | Mode register |
| conf_o | output | 24 | Configuration register |
| gpo_o | output | 8 | Output-control register |
| offs_o | output | 24 | Offset register |
| fscl_o | output | 24 | Full-scale register |
| stream_o | output | 1 | Streaming mode active |

## Verification
In streaming mode, the output shifter and the command shifter share the same serial-clock edges. A stopping command can therefore complete while a conversion word is still leaving on the output. The bench provokes this by dropping the ready strobe and then clocking the 0x58 command in on the first eight edges of the 24-bit stream. It judges the result by the full word arriving intact on the output and by the streaming flag clearing once the command completes.

// File: rtl/sri_pkg.sv
package sri_pkg;
   typedef enum logic [2:0] {
      ADR_CTRL  = 3'd0,
      ADR_MODE  = 3'd1,
      ADR_CONF  = 3'd2,
      ADR_DATA  = 3'd3,
      ADR_IDENT = 3'd4,
      ADR_GPO   = 3'd5,
      ADR_OFFS  = 3'd6,
      ADR_FSCL  = 3'd7
   } reg_addr_e;

   typedef enum logic {
      ST_CMD  = 1'b0,
      ST_XFER = 1'b1
   } if_state_e;

   localparam int          CMD_BITS      = 8;
   localparam logic [7:0]  CMD_STREAM_ON  = 8'h5C;
   localparam logic [7:0]  CMD_STREAM_OFF = 8'h58;
endpackage

// File: rtl/sri_sync.sv
module sri_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sri_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];
   logic [WIDTH-1:0] prev_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= stg[STAGES-1];
   end

   assign sync_o = stg[STAGES-1];
   assign rise_o = stg[STAGES-1] & ~prev_q;
   assign fall_o = ~stg[STAGES-1] & prev_q;
endmodule

// File: rtl/sri_ones_det.sv
module sri_ones_det #(
   parameter int LIMIT = 40,
   localparam int CW   = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_en,
   input  logic bit_i,
   output logic hit_o
);
   if (LIMIT < 2) begin : g_bad_limit
      $error("sri_ones_det: LIMIT must be at least 2");
   end

   logic [CW-1:0] run_q;

   assign hit_o = sample_en && bit_i && (run_q == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (sample_en) begin
         if (!bit_i || hit_o) run_q <= '0;
         else                 run_q <= run_q + 1'b1;
      end
   end

   // R10: the run counter never reaches the limit itself
   p_run_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      run_q < CW'(LIMIT));

   // R10: a zero sample breaks the run
   p_run_break_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && !bit_i) |=> (run_q == '0));
endmodule

// File: rtl/sri_regs.sv
module sri_regs
   import sri_pkg::*;
#(
   parameter int REG_W       = 24,
   parameter int STAT_W      = 8,
   parameter int APPEND_BIT  = 20,
   parameter logic [REG_W-1:0]  MODE_RST = 24'h080060,
   parameter logic [REG_W-1:0]  CONF_RST = 24'h000117,
   parameter logic [REG_W-1:0]  OFFS_RST = 24'h800000,
   parameter logic [REG_W-1:0]  FSCL_RST = 24'h5A0000,
   parameter logic [STAT_W-1:0] GPO_RST  = 8'h00,
   parameter logic [STAT_W-1:0] ID_VAL   = 8'hA4,
   localparam int WORD_W = REG_W + STAT_W,
   localparam int CNT_W  = $clog2(WORD_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               wr_en,
   input  reg_addr_e          wr_addr,
   input  logic [REG_W-1:0]   wr_data,
   input  reg_addr_e          sel_addr,
   input  logic [REG_W-1:0]   conv_data,
   input  logic [STAT_W-1:0]  status,
   output logic [WORD_W-1:0]  sel_word,
   output logic [CNT_W-1:0]   sel_len,
   output logic [REG_W-1:0]   mode_o,
   output logic [REG_W-1:0]   conf_o,
   output logic [REG_W-1:0]   offs_o,
   output logic [REG_W-1:0]   fscl_o,
   output logic [STAT_W-1:0]  gpo_o
);
   if (APPEND_BIT >= REG_W) begin : g_bad_append
      $error("sri_regs: APPEND_BIT outside register");
   end
   if (REG_W < STAT_W) begin : g_bad_width
      $error("sri_regs: REG_W must not be below STAT_W");
   end

   localparam int NWIDE = 4;
   localparam reg_addr_e        WIDE_ADR [NWIDE] = '{ADR_MODE, ADR_CONF, ADR_OFFS, ADR_FSCL};
   localparam logic [REG_W-1:0] WIDE_RST [NWIDE] = '{MODE_RST, CONF_RST, OFFS_RST, FSCL_RST};

   logic [REG_W-1:0]  wide_q [NWIDE];
   logic [STAT_W-1:0] gpo_q;

   for (genvar g = 0; g < NWIDE; g++) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              wide_q[g] <= WIDE_RST[g];
         else if (clr)                            wide_q[g] <= WIDE_RST[g];
         else if (wr_en && wr_addr == WIDE_ADR[g]) wide_q[g] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            gpo_q <= GPO_RST;
      else if (clr)                          gpo_q <= GPO_RST;
      else if (wr_en && wr_addr == ADR_GPO)  gpo_q <= wr_data[STAT_W-1:0];
   end

   assign mode_o = wide_q[0];
   assign conf_o = wide_q[1];
   assign offs_o = wide_q[2];
   assign fscl_o = wide_q[3];
   assign gpo_o  = gpo_q;

   always_comb begin
      sel_word = '0;
      sel_len  = CNT_W'(REG_W);
      unique case (sel_addr)
         ADR_CTRL: begin
            sel_word = {{REG_W{1'b0}}, status};
            sel_len  = CNT_W'(STAT_W);
         end
         ADR_MODE: sel_word = {{STAT_W{1'b0}}, wide_q[0]};
         ADR_CONF: sel_word = {{STAT_W{1'b0}}, wide_q[1]};
         ADR_DATA: begin
            if (wide_q[0][APPEND_BIT]) begin
               sel_word = {conv_data, status};
               sel_len  = CNT_W'(WORD_W);
            end else begin
               sel_word = {{STAT_W{1'b0}}, conv_data};
            end
         end
         ADR_IDENT: begin
            sel_word = {{REG_W{1'b0}}, ID_VAL};
            sel_len  = CNT_W'(STAT_W);
         end
         ADR_GPO: begin
            sel_word = {{REG_W{1'b0}}, gpo_q};
            sel_len  = CNT_W'(STAT_W);
         end
         ADR_OFFS: sel_word = {{STAT_W{1'b0}}, wide_q[2]};
         ADR_FSCL: sel_word = {{STAT_W{1'b0}}, wide_q[3]};
         default: ;
      endcase
   end

   // R7: a write aimed at a read-only address leaves every register unchanged
   p_ro_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr && (wr_addr == ADR_DATA || wr_addr == ADR_IDENT || wr_addr == ADR_CTRL))
      |=> ($stable(wide_q[0]) && $stable(wide_q[1]) && $stable(wide_q[2])
           && $stable(wide_q[3]) && $stable(gpo_q)));

   // R10: a framing reset restores every default
   p_clr_defaults_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (wide_q[0] == MODE_RST && gpo_q == GPO_RST && wide_q[3] == FSCL_RST));
endmodule

// File: rtl/sri_cmd_if.sv
module sri_cmd_if
   import sri_pkg::*;
#(
   parameter int REG_W       = 24,
   parameter int STAT_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ONES_LIMIT  = 40,
   parameter int APPEND_BIT  = 20,
   parameter logic [REG_W-1:0]  MODE_RST = 24'h080060,
   parameter logic [REG_W-1:0]  CONF_RST = 24'h000117,
   parameter logic [REG_W-1:0]  OFFS_RST = 24'h800000,
   parameter logic [REG_W-1:0]  FSCL_RST = 24'h5A0000,
   parameter logic [STAT_W-1:0] GPO_RST  = 8'h00,
   parameter logic [STAT_W-1:0] ID_VAL   = 8'hA4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              din,
   output logic              dout,
   input  logic              rdy_n,
   input  logic [REG_W-1:0]  conv_data_i,
   input  logic [STAT_W-1:0] status_i,
   output logic [REG_W-1:0]  mode_o,
   output logic [REG_W-1:0]  conf_o,
   output logic [STAT_W-1:0] gpo_o,
   output logic [REG_W-1:0]  offs_o,
   output logic [REG_W-1:0]  fscl_o,
   output logic              stream_o
);
   localparam int WORD_W = REG_W + STAT_W;
   localparam int CNT_W  = $clog2(WORD_W + 1);
   localparam int CSR_W  = CMD_BITS - 2;

   if (STAT_W != CMD_BITS) begin : g_bad_stat
      $error("sri_cmd_if: STAT_W must equal the command length");
   end

   // ---------------- synchronized pins ----------------
   logic [2:0] pin_s, pin_r, pin_f;
   sri_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i({cs_n, sclk, din}),
      .sync_o(pin_s), .rise_o(pin_r), .fall_o(pin_f));

   logic cs_act, sclk_r, sclk_f, din_s;
   assign cs_act = ~pin_s[2];
   assign sclk_r = pin_r[1] & cs_act;
   assign sclk_f = pin_f[1] & cs_act;
   assign din_s  = pin_s[0];

   // ---------------- framing recovery ----------------
   logic resync;
   sri_ones_det #(.LIMIT(ONES_LIMIT)) u_ones (
      .clk(clk), .rst_n(rst_n), .sample_en(sclk_r), .bit_i(din_s), .hit_o(resync));

   // ---------------- state ----------------
   if_state_e        state_q;
   logic [CNT_W-1:0] bit_cnt_q, len_q, out_left_q;
   logic [CSR_W-1:0] cmd_sr_q;
   reg_addr_e        addr_q;
   logic             rd_q, cread_q, dout_q, rdy_q;
   logic [WORD_W-1:0] in_sr_q, out_sr_q;

   logic [7:0]        cmd_full;
   reg_addr_e         dec_adr, sel_addr;
   logic [WORD_W-1:0] sel_word, load_word;
   logic [CNT_W-1:0]  sel_len;
   logic              wr_en, xfer_last, rdy_fall;
   logic [REG_W-1:0]  wr_data;

   assign cmd_full  = {1'b0, cmd_sr_q, din_s};
   assign dec_adr   = reg_addr_e'(cmd_full[5:3]);
   assign sel_addr  = cread_q ? ADR_DATA : ((state_q == ST_XFER) ? addr_q : dec_adr);
   assign load_word = sel_word << (CNT_W'(WORD_W) - sel_len);
   assign xfer_last = (bit_cnt_q == len_q - 1'b1);
   assign wr_data   = REG_W'({in_sr_q[WORD_W-2:0], din_s});
   assign wr_en     = (state_q == ST_XFER) && sclk_r && xfer_last && !rd_q && !resync;
   assign rdy_fall  = rdy_q && !rdy_n;

   sri_regs #(
      .REG_W(REG_W), .STAT_W(STAT_W), .APPEND_BIT(APPEND_BIT),
      .MODE_RST(MODE_RST), .CONF_RST(CONF_RST), .OFFS_RST(OFFS_RST),
      .FSCL_RST(FSCL_RST), .GPO_RST(GPO_RST), .ID_VAL(ID_VAL)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .clr(resync),
      .wr_en(wr_en), .wr_addr(addr_q), .wr_data(wr_data),
      .sel_addr(sel_addr), .conv_data(conv_data_i), .status(status_i),
      .sel_word(sel_word), .sel_len(sel_len),
      .mode_o(mode_o), .conf_o(conf_o), .offs_o(offs_o), .fscl_o(fscl_o), .gpo_o(gpo_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdy_q <= 1'b1;
      else        rdy_q <= rdy_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_CMD;
         bit_cnt_q  <= '0;
         len_q      <= '0;
         out_left_q <= '0;
         cmd_sr_q   <= '0;
         addr_q     <= ADR_CTRL;
         rd_q       <= 1'b0;
         cread_q    <= 1'b0;
         dout_q     <= 1'b0;
         in_sr_q    <= '0;
         out_sr_q   <= '0;
      end else if (resync) begin
         state_q    <= ST_CMD;
         bit_cnt_q  <= '0;
         out_left_q <= '0;
         cmd_sr_q   <= '0;
         cread_q    <= 1'b0;
      end else if (!cs_act) begin
         state_q    <= ST_CMD;
         bit_cnt_q  <= '0;
         out_left_q <= '0;
      end else begin
         // output side: bits leave on falling edges
         if (sclk_f) begin
            if (out_left_q != '0) begin
               dout_q     <= out_sr_q[WORD_W-1];
               out_sr_q   <= out_sr_q << 1;
               out_left_q <= out_left_q - 1'b1;
            end else begin
               dout_q <= 1'b0;
            end
         end
         // streaming load wins over a coincident shift
         if (cread_q && rdy_fall) begin
            out_sr_q   <= load_word;
            out_left_q <= sel_len;
         end
         // input side: bits arrive on rising edges
         if (sclk_r) begin
            unique case (state_q)
               ST_CMD: begin
                  if (bit_cnt_q == '0) begin
                     if (!din_s) bit_cnt_q <= CNT_W'(1);
                  end else if (bit_cnt_q != CNT_W'(CMD_BITS - 1)) begin
                     cmd_sr_q  <= {cmd_sr_q[CSR_W-2:0], din_s};
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                  end else begin
                     bit_cnt_q <= '0;
                     if (cread_q) begin
                        if (cmd_full == CMD_STREAM_OFF && !rdy_n) cread_q <= 1'b0;
                     end else if (cmd_full[6] && dec_adr == ADR_DATA && cmd_full[2]) begin
                        cread_q <= 1'b1;
                     end else if (!cmd_full[6] && dec_adr == ADR_CTRL) begin
                        state_q <= ST_CMD;
                     end else begin
                        state_q <= ST_XFER;
                        addr_q  <= dec_adr;
                        rd_q    <= cmd_full[6];
                        len_q   <= sel_len;
                        if (cmd_full[6]) begin
                           out_sr_q   <= load_word;
                           out_left_q <= sel_len;
                        end
                     end
                  end
               end
               ST_XFER: begin
                  in_sr_q <= {in_sr_q[WORD_W-2:0], din_s};
                  if (xfer_last) begin
                     state_q   <= ST_CMD;
                     bit_cnt_q <= '0;
                  end else begin
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign dout     = dout_q;
   assign stream_o = cread_q;

   // R12: the output bit moves only after a falling serial-clock edge
   p_dout_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout_q) |-> $past(sclk_f));

   // R8: streaming turns on only as a command completes
   p_stream_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cread_q) |-> ($past(sclk_r) && $past(state_q == ST_CMD)));

   // R11: deselect returns the port to command wait
   p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_act && !resync) |=> (state_q == ST_CMD && out_left_q == '0 && $stable(cread_q)));

   // R10: framing reset clears streaming and the command position
   p_resync_r10: assert property (@(posedge clk) disable iff (!rst_n)
      resync |=> (!cread_q && state_q == ST_CMD && bit_cnt_q == '0));

   // R2: a leading one keeps the port at the gate position
   p_gate_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && sclk_r && !resync && state_q == ST_CMD && bit_cnt_q == '0 && din_s)
      |=> (bit_cnt_q == '0));

   // R6: the output shifter never holds more than one full word
   p_out_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_left_q <= CNT_W'(WORD_W));
endmodule

// File: tb/sri_cmd_if_tb_top.sv
module sri_cmd_if_tb_top;
   localparam int HALF = 8;
   localparam logic [23:0] MODE_D = 24'h080060;
   localparam logic [23:0] CONF_D = 24'h000117;
   localparam logic [23:0] OFFS_D = 24'h800000;
   localparam logic [23:0] FSCL_D = 24'h5A0000;
   localparam logic [7:0]  GPO_D  = 8'h00;
   localparam logic [7:0]  ID_D   = 8'hA4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b1, din = 1'b0, rdy_n = 1'b1;
   logic dout, stream_o;
   logic [23:0] conv_data = 24'h000000;
   logic [7:0]  status = 8'h5A;
   logic [23:0] mode_o, conf_o, offs_o, fscl_o;
   logic [7:0]  gpo_o;

   always #2.5 clk = ~clk;

   sri_cmd_if dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout),
      .rdy_n(rdy_n), .conv_data_i(conv_data), .status_i(status),
      .mode_o(mode_o), .conf_o(conf_o), .gpo_o(gpo_o), .offs_o(offs_o),
      .fscl_o(fscl_o), .stream_o(stream_o));

   int n_tests = 0;
   int n_fail  = 0;

   typedef struct {
      string       tag;
      logic [31:0] exp;
   } item_t;
   item_t       sb_q[$];
   logic [31:0] mon_val;
   event        mon_ev;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // monitor: pop expected items as serial results arrive
   initial begin
      forever begin
         item_t it;
         @(mon_ev);
         if (sb_q.size() == 0) begin
            chk("scoreboard-empty", 32'h1, 32'h0);
         end else begin
            it = sb_q.pop_front();
            chk(it.tag, mon_val, it.exp);
         end
      end
   end

   task automatic sbit(input logic b, output logic o);
      @(negedge clk);
      sclk = 1'b0;
      din  = b;
      repeat (HALF) @(negedge clk);
      o    = dout;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic shift(input logic [31:0] v, input int n, output logic [31:0] got);
      got = '0;
      for (int i = n - 1; i >= 0; i--) begin
         logic o;
         sbit(v[i], o);
         got = {got[30:0], o};
      end
   endtask

   task automatic cmd(input logic [7:0] c);
      logic [31:0] g;
      shift({24'h0, c}, 8, g);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] v, input int n);
      logic [31:0] g;
      cmd({2'b00, a, 3'b000});
      shift(v, n, g);
   endtask

   // driver: push the expectation, then run the read
   task automatic rd_exp(input string tag, input logic [2:0] a, input int n, input logic [31:0] exp);
      logic [31:0] g;
      sb_q.push_back('{tag, exp});
      cmd({2'b01, a, 3'b000});
      shift(32'h0, n, g);
      mon_val = g;
      -> mon_ev;
      @(negedge clk);
   endtask

   task automatic stream_exp(input string tag, input logic [31:0] cmdbits, input logic [31:0] exp);
      logic [31:0] g;
      sb_q.push_back('{tag, exp});
      shift(cmdbits, 24, g);
      mon_val = g;
      -> mon_ev;
      @(negedge clk);
   endtask

   task automatic ones(input int n);
      for (int i = 0; i < n; i++) begin
         logic o;
         sbit(1'b1, o);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [31:0] g;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 mode", {8'h0, mode_o}, {8'h0, MODE_D});
      chk("R1 conf", {8'h0, conf_o}, {8'h0, CONF_D});
      chk("R1 offs", {8'h0, offs_o}, {8'h0, OFFS_D});
      chk("R1 fscl", {8'h0, fscl_o}, {8'h0, FSCL_D});
      chk("R1 gpo", {24'h0, gpo_o}, {24'h0, GPO_D});
      chk("R1 stream", {31'h0, stream_o}, 32'h0);
      chk("R1 dout", {31'h0, dout}, 32'h0);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);

      // R4 / R12 reads of defaults
      rd_exp("R4 id", 3'd4, 8, {24'h0, ID_D});
      rd_exp("R4 R12 mode", 3'd1, 24, {8'h0, MODE_D});
      rd_exp("R4 gpo", 3'd5, 8, {24'h0, GPO_D});
      // R5 status via address 0
      rd_exp("R5 status", 3'd0, 8, 32'h5A);

      // R3 writes
      wr(3'd1, 32'h0A3456, 24);
      chk("R3 mode", {8'h0, mode_o}, 32'h0A3456);
      wr(3'd5, 32'hC3, 8);
      chk("R3 gpo", {24'h0, gpo_o}, 32'hC3);
      wr(3'd6, 32'h13579B, 24);
      chk("R3 offs", {8'h0, offs_o}, 32'h13579B);
      wr(3'd7, 32'h7E0001, 24);
      rd_exp("R3 fscl readback", 3'd7, 24, 32'h7E0001);

      // R2 leading ones before the gate bit
      shift(32'h1F, 5, g);
      wr(3'd2, 32'hABCDEF, 24);
      chk("R2 conf after gate ones", {8'h0, conf_o}, 32'hABCDEF);

      // R6 data word, plain and with status appended
      conv_data = 24'h9876AB;
      rd_exp("R6 data24", 3'd3, 24, 32'h009876AB);
      wr(3'd1, 32'h1A3456, 24);
      rd_exp("R6 data32", 3'd3, 32, {24'h9876AB, 8'h5A});
      wr(3'd1, 32'h0A3456, 24);

      // R7 discarded writes
      wr(3'd3, 32'h0F0F0F, 24);
      wr(3'd4, 32'h11, 8);
      cmd(8'h00);
      chk("R7 mode kept", {8'h0, mode_o}, 32'h0A3456);
      chk("R7 conf kept", {8'h0, conf_o}, 32'hABCDEF);
      chk("R7 gpo kept", {24'h0, gpo_o}, 32'hC3);
      rd_exp("R7 id kept", 3'd4, 8, {24'h0, ID_D});

      // R8 streaming on
      cmd(8'h5C);
      chk("R8 stream on", {31'h0, stream_o}, 32'h1);
      // R9 ignored commands
      cmd(8'h58);
      chk("R9 stop ignored while ready high", {31'h0, stream_o}, 32'h1);
      cmd(8'h28);
      chk("R9 other command ignored", {31'h0, stream_o}, 32'h1);
      chk("R9 gpo untouched", {24'h0, gpo_o}, 32'hC3);
      conv_data = 24'h13579B;
      @(negedge clk); rdy_n = 1'b0;
      stream_exp("R8 stream word1", 32'h0, 32'h0013579B);
      @(negedge clk); rdy_n = 1'b1;
      conv_data = 24'h2468AC;
      @(negedge clk); rdy_n = 1'b0;
      stream_exp("R8 stream word2", 32'h0, 32'h002468AC);
      @(negedge clk); rdy_n = 1'b1;

      // R11 deselect mid-stream keeps the mode
      conv_data = 24'h55AA55;
      @(negedge clk); rdy_n = 1'b0;
      shift(32'h0, 8, g);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      chk("R11 stream kept", {31'h0, stream_o}, 32'h1);
      @(negedge clk); rdy_n = 1'b1;

      // R9 stop command landing inside a stream
      conv_data = 24'hC0FFEE;
      @(negedge clk); rdy_n = 1'b0;
      stream_exp("R9 word during stop", {8'h0, 8'h58, 16'h0}, 32'h00C0FFEE);
      chk("R9 stream off", {31'h0, stream_o}, 32'h0);
      @(negedge clk); rdy_n = 1'b1;

      // R11 partial write aborted
      cmd(8'h08);
      shift(32'h3FF, 10, g);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      chk("R11 mode unchanged", {8'h0, mode_o}, 32'h0A3456);
      rd_exp("R11 conf after abort", 3'd2, 24, 32'hABCDEF);

      // R10 run of ones: 39 keeps state, 40th resets
      cmd(8'h5C);
      ones(39);
      chk("R10 39 ones stream kept", {31'h0, stream_o}, 32'h1);
      chk("R10 39 ones gpo kept", {24'h0, gpo_o}, 32'hC3);
      ones(1);
      chk("R10 stream cleared", {31'h0, stream_o}, 32'h0);
      chk("R10 gpo default", {24'h0, gpo_o}, {24'h0, GPO_D});
      chk("R10 mode default", {8'h0, mode_o}, {8'h0, MODE_D});
      chk("R10 conf default", {8'h0, conf_o}, {8'h0, CONF_D});
      rd_exp("R10 id after resync", 3'd4, 8, {24'h0, ID_D});

      repeat (10) @(negedge clk);
      summary();
   end
endmodule